// File: doc/BRIEF.md
# Interrupt Context Frame Sequencer

This block is the part of a small CPU core that stores the execution context when an interrupt is taken and reloads it when the handler returns. It owns four architectural registers: a 19-bit program counter, an 8-bit status word whose top two bits form the interrupt mask, a 16-bit auxiliary address register, and a stack pointer. Arbitration between interrupt sources and the fetch of the handler address happen elsewhere. The handler address and the level of the accepted interrupt arrive together with the accept strobe.

On an accept strobe the block moves the stack pointer down by six. It then writes a six-byte frame, one byte per clock, through a byte-wide synchronous memory port. After the frame is written it replaces the mask with the new level and jumps to the handler. On a return strobe it reads the same six bytes back in the opposite order, restores the three registers, and releases the frame.

Top module: `irq_frame_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the program counter, the status word and the auxiliary register. It loads the stack pointer with `SP_INIT` and drives `busy` and `done` low.
- R2: On entry the stack pointer becomes its old value minus 6. The frame is written at the new value SP as follows. SP+0 holds the status word. SP+1 holds PC[8:1] and SP+2 holds PC[16:9]. SP+3 holds PC[0] in bit 7, zeros in bits 6..2, PC[18] in bit 1 and PC[17] in bit 0. SP+4 holds the auxiliary register's low byte and SP+5 its high byte.
- R3: Entry writes one byte per clock, always at descending addresses: SP+5 first and SP+0 last, six writes in total. `mem_we` is never high while the block is idle.
- R4: After entry, status bits 7..6 equal the accepted level and status bits 5..0 are unchanged. The program counter equals the supplied vector and the auxiliary register is unchanged.
- R5: A return reads SP+0 through SP+5 in ascending order. Read data is taken one cycle after its address. The return restores the status word, then the program counter, then the auxiliary register from the layout of R2, and finally adds 6 to the stack pointer.
- R6: On a return, bits 6..2 of the byte at SP+3 have no effect on any register.
- R7: Both sequences keep `busy` high for exactly 7 cycles. `done` is then high for exactly one cycle, the first cycle with `busy` low, and the updated registers are already visible in that cycle.
- R8: Accept and return strobes that arrive while `busy` is high are ignored.
- R9: If accept and return are strobed in the same idle cycle, entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accept | input | 1 | Interrupt accept strobe |
| level | input | 2 | Level of the accepted interrupt |
| vector | input | 19 | Handler address |
| rti | input | 1 | Return-from-interrupt strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 19 | Program counter |
| psw | output | 8 | Status word, mask in bits 7..6 |
| aux | output | 16 | Auxiliary address register |
| sp | output | SP_W | Stack pointer |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | SP_W | Stack memory byte address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, one cycle after its address |

## Verification
A wrong step index or a wrong packing slot places a PC fragment in the wrong byte. This shows in the stack memory as soon as entry completes, and a round trip with a later return exposes it in the restored `pc` within 14 cycles. An off-by-one in the read pipeline shifts every restored byte by one slot, so `psw`, `pc` and `aux` are all wrong when `done` rises. A state machine that does not ignore strobes while busy, or that gets its cycle count wrong, changes the `busy` length or the stack pointer on the same sequence. The bench sweeps many packed register values and reserved-bit patterns to catch these faults.

// File: rtl/irq_frame_pkg.sv
// Package: shared constants and types for the interrupt frame sequencer.
// Assumes a fixed six-byte frame and a 19-bit program counter.
package irq_frame_pkg;
    localparam int FRAME_BYTES = 6;
    localparam int IDX_W       = 3;
    localparam int PC_W        = 19;
    localparam int PSW_W       = 8;
    localparam int AUX_W       = 16;
    localparam int LVL_W       = 2;
    localparam int MASK_LO     = PSW_W - LVL_W;

    // Frame slot offsets from the frame base.
    localparam int SLOT_PSW  = 0;
    localparam int SLOT_PCL  = 1;
    localparam int SLOT_PCH  = 2;
    localparam int SLOT_PCX  = 3;
    localparam int SLOT_AUXL = 4;
    localparam int SLOT_AUXH = 5;

    // Bit positions inside the mixed PC byte.
    localparam int PCX_PC0  = 7;
    localparam int PCX_PC18 = 1;
    localparam int PCX_PC17 = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PUSH_FIN,
        ST_POP,
        ST_POP_FIN
    } seq_state_t;
endpackage

// File: rtl/ifs_ctrl.sv
// Module: ifs_ctrl
// Sequencing state machine. It steps a slot index down for entry and up for
// return, and keeps a one-cycle-delayed copy of the index to match the memory
// read latency. Assumes strobes are single-cycle and are only honoured when idle.
module ifs_ctrl import irq_frame_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             rti,
    output seq_state_t       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             start_push_o,
    output logic             finish_push_o,
    output logic             finish_pop_o,
    output logic             cap_valid_o,
    output logic [IDX_W-1:0] cap_idx_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             cap_valid_q;
    logic [IDX_W-1:0] cap_idx_q;

    // State, slot index, completion pulse and read-capture pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            done_q      <= 1'b0;
            cap_valid_q <= 1'b0;
            cap_idx_q   <= '0;
        end else begin
            done_q      <= (state_q == ST_PUSH_FIN) || (state_q == ST_POP_FIN);
            cap_valid_q <= (state_q == ST_POP);
            cap_idx_q   <= idx_q;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_PUSH;
                        idx_q   <= IDX_LAST;
                    end else if (rti) begin
                        state_q <= ST_POP;
                        idx_q   <= '0;
                    end
                end
                ST_PUSH: begin
                    if (idx_q == '0) state_q <= ST_PUSH_FIN;
                    else             idx_q   <= idx_q - 1'b1;
                end
                ST_PUSH_FIN: state_q <= ST_IDLE;
                ST_POP: begin
                    if (idx_q == IDX_LAST) state_q <= ST_POP_FIN;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                ST_POP_FIN: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the register file.
    always_comb begin
        state_o       = state_q;
        idx_o         = idx_q;
        start_push_o  = (state_q == ST_IDLE) && accept;
        finish_push_o = (state_q == ST_PUSH_FIN);
        finish_pop_o  = (state_q == ST_POP_FIN);
        cap_valid_o   = cap_valid_q;
        cap_idx_o     = cap_idx_q;
        busy_o        = (state_q != ST_IDLE);
        done_o        = done_q;
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));
    // R8
    push_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH) |=> (state_q == ST_PUSH) || (state_q == ST_PUSH_FIN));
    // R8
    pop_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP) |=> (state_q == ST_POP) || (state_q == ST_POP_FIN));
    // R9
    accept_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && accept && rti) |=> (state_q == ST_PUSH));
endmodule

// File: rtl/ifs_pack.sv
// Module: ifs_pack
// Selects the frame byte that belongs to a slot, from the live registers.
// Assumes the registers do not change while the frame is being written.
module ifs_pack import irq_frame_pkg::*; (
    input  logic [IDX_W-1:0] slot,
    input  logic [PC_W-1:0]  pc,
    input  logic [PSW_W-1:0] psw,
    input  logic [AUX_W-1:0] aux,
    output logic [7:0]       byte_o
);
    // Slot-to-byte mapping; reserved bits of the mixed byte read as zero.
    always_comb begin
        byte_o = 8'h00;
        case (int'(slot))
            SLOT_PSW:  byte_o = psw;
            SLOT_PCL:  byte_o = pc[8:1];
            SLOT_PCH:  byte_o = pc[16:9];
            SLOT_PCX: begin
                byte_o[PCX_PC0]  = pc[0];
                byte_o[PCX_PC18] = pc[18];
                byte_o[PCX_PC17] = pc[17];
            end
            SLOT_AUXL: byte_o = aux[7:0];
            SLOT_AUXH: byte_o = aux[15:8];
            default:   byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/ifs_unpack.sv
// Module: ifs_unpack
// Merges one returned frame byte into the register values that come next.
// Assumes cap_slot names the slot whose data is on rdata this cycle.
module ifs_unpack import irq_frame_pkg::*; (
    input  logic             cap_valid,
    input  logic [IDX_W-1:0] cap_slot,
    input  logic [7:0]       rdata,
    input  logic [PC_W-1:0]  pc,
    input  logic [PSW_W-1:0] psw,
    input  logic [AUX_W-1:0] aux,
    output logic [PC_W-1:0]  pc_n,
    output logic [PSW_W-1:0] psw_n,
    output logic [AUX_W-1:0] aux_n
);
    // Default hold; overwrite only the fields that the captured slot carries.
    always_comb begin
        pc_n  = pc;
        psw_n = psw;
        aux_n = aux;
        if (cap_valid) begin
            case (int'(cap_slot))
                SLOT_PSW:  psw_n = rdata;
                SLOT_PCL:  pc_n[8:1] = rdata;
                SLOT_PCH:  pc_n[16:9] = rdata;
                SLOT_PCX: begin
                    pc_n[0]  = rdata[PCX_PC0];
                    pc_n[18] = rdata[PCX_PC18];
                    pc_n[17] = rdata[PCX_PC17];
                end
                SLOT_AUXL: aux_n[7:0] = rdata;
                SLOT_AUXH: aux_n[15:8] = rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_frame_seq.sv
// Module: irq_frame_seq (top)
// Holds PC, status word, auxiliary register and stack pointer. Saves them as a
// six-byte frame on interrupt entry and restores them on return.
// Assumes a stack memory with single-cycle writes and one-cycle read latency.
module irq_frame_seq import irq_frame_pkg::*; #(
    parameter int             SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = SP_W'(16'h0100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [1:0]       level,
    input  logic [18:0]      vector,
    input  logic             rti,
    output logic             busy,
    output logic             done,
    output logic [18:0]      pc,
    output logic [7:0]       psw,
    output logic [15:0]      aux,
    output logic [SP_W-1:0]  sp,
    output logic             mem_we,
    output logic [SP_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam logic [SP_W-1:0] FRAME_SZ = SP_W'(FRAME_BYTES);

    seq_state_t       state;
    logic [IDX_W-1:0] idx, cap_idx;
    logic             start_push, finish_push, finish_pop, cap_valid;
    logic [PC_W-1:0]  pc_q, pc_n, vec_q;
    logic [PSW_W-1:0] psw_q, psw_n;
    logic [AUX_W-1:0] aux_q, aux_n;
    logic [LVL_W-1:0] lvl_q;
    logic [SP_W-1:0]  sp_q;
    logic [7:0]       wbyte;

    ifs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .rti          (rti),
        .state_o      (state),
        .idx_o        (idx),
        .start_push_o (start_push),
        .finish_push_o(finish_push),
        .finish_pop_o (finish_pop),
        .cap_valid_o  (cap_valid),
        .cap_idx_o    (cap_idx),
        .busy_o       (busy),
        .done_o       (done)
    );

    ifs_pack u_pack (
        .slot  (idx),
        .pc    (pc_q),
        .psw   (psw_q),
        .aux   (aux_q),
        .byte_o(wbyte)
    );

    ifs_unpack u_unpack (
        .cap_valid(cap_valid),
        .cap_slot (cap_idx),
        .rdata    (mem_rdata),
        .pc       (pc_q),
        .psw      (psw_q),
        .aux      (aux_q),
        .pc_n     (pc_n),
        .psw_n    (psw_n),
        .aux_n    (aux_n)
    );

    // Stack pointer moves and latching of the entry parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= SP_INIT;
            vec_q <= '0;
            lvl_q <= '0;
        end else if (start_push) begin
            sp_q  <= sp_q - FRAME_SZ;
            vec_q <= vector;
            lvl_q <= level;
        end else if (finish_pop) begin
            sp_q  <= sp_q + FRAME_SZ;
        end
    end

    // Architectural registers: handler jump at entry end, byte merge on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
            aux_q <= '0;
        end else if (finish_push) begin
            pc_q                    <= vec_q;
            psw_q[PSW_W-1:MASK_LO]  <= lvl_q;
        end else begin
            pc_q  <= pc_n;
            psw_q <= psw_n;
            aux_q <= aux_n;
        end
    end

    // Memory port and register outputs.
    always_comb begin
        mem_we    = (state == ST_PUSH);
        mem_addr  = sp_q + SP_W'(idx);
        mem_wdata = wbyte;
        pc        = pc_q;
        psw       = psw_q;
        aux       = aux_q;
        sp        = sp_q;
    end

    // R2
    sp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_push |=> (sp_q == $past(sp_q) - FRAME_SZ));
    // R5
    sp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_pop |=> (sp_q == $past(sp_q) + FRAME_SZ));
    // R3
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
    // R3
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_addr == sp_q + SP_W'(SLOT_PCX))) |-> (mem_wdata[6:2] == 5'd0));
    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_push |=> (psw_q[PSW_W-1:MASK_LO] == $past(lvl_q)) && (pc_q == $past(vec_q)));
endmodule

// File: tb/test_irq_frame_seq.sv
// Bench: sweeps entry/return round trips over many register patterns and checks
// frame bytes, write order, timing and ignored strobes against computed values.
module test_irq_frame_seq;
    localparam logic [15:0] SP0 = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept = 1'b0, rti = 1'b0;
    logic [1:0]  level = '0;
    logic [18:0] vector = '0;
    logic        busy, done, mem_we;
    logic [18:0] pc;
    logic [7:0]  psw, mem_wdata, mem_rdata;
    logic [15:0] aux, sp, mem_addr;

    logic [7:0]  mem [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = '0, poke_data = '0;
    logic        log_clr = 1'b0;
    logic [15:0] wlog [8];
    int          wcnt;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    irq_frame_seq #(.SP_W(16), .SP_INIT(SP0)) i_irq_frame_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .level(level), .vector(vector),
        .rti(rti), .busy(busy), .done(done), .pc(pc), .psw(psw), .aux(aux), .sp(sp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Stack memory model: synchronous write, one-cycle read, bench poke port.
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    // Write address log for order checks.
    always @(posedge clk) begin
        if (log_clr) wcnt <= 0;
        else if (mem_we) begin
            if (wcnt < 8) wlog[wcnt] <= mem_addr;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk); poke_en = 1'b0;
    endtask

    // Issue a strobe; optionally inject both strobes while busy; measure busy length.
    task automatic run_seq(input bit do_acc, input bit both, input int inject,
                           input logic [18:0] v, input logic [1:0] l, output int cyc);
        @(negedge clk);
        accept = do_acc | both; rti = ~do_acc | both; vector = v; level = l;
        @(negedge clk);
        accept = 1'b0; rti = 1'b0; vector = ~v; level = ~l;
        cyc = 0;
        while (busy && cyc < 50) begin
            if (cyc == inject) begin accept = 1'b1; rti = 1'b1; end
            @(negedge clk);
            accept = 1'b0; rti = 1'b0;
            cyc++;
        end
        chk("R7 done with busy low", {31'd0, done}, 32'd1);
        @(negedge clk);
        chk("R7 done single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [15:0] spx;
        int cyc;
        spx = SP0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", {13'd0, pc}, 32'd0);
        chk("R1 psw", {24'd0, psw}, 32'd0);
        chk("R1 aux", {16'd0, aux}, 32'd0);
        chk("R1 sp", {16'd0, sp}, {16'd0, SP0});
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 no write idle", {31'd0, mem_we}, 32'd0);

        for (int i = 0; i < 40; i++) begin
            logic [18:0] ppc, vec;
            logic [7:0]  ppsw;
            logic [15:0] paux, b;
            logic [4:0]  junk;
            logic [1:0]  lvl;
            ppc  = 19'((i * 20011 + 7) * 13);
            ppsw = 8'(i * 37 + 5);
            paux = 16'(i * 4099 + 3);
            junk = 5'(i * 13);
            vec  = 19'(i * 7919 + 1);
            lvl  = 2'(i);
            // Preload a frame at the current SP, then return from it.
            poke(spx[7:0] + 8'd0, ppsw);
            poke(spx[7:0] + 8'd1, ppc[8:1]);
            poke(spx[7:0] + 8'd2, ppc[16:9]);
            poke(spx[7:0] + 8'd3, {ppc[0], junk, ppc[18], ppc[17]});
            poke(spx[7:0] + 8'd4, paux[7:0]);
            poke(spx[7:0] + 8'd5, paux[15:8]);
            run_seq(1'b0, 1'b0, (i % 3 == 1) ? 3 : -1, 19'h0, 2'd0, cyc);
            chk("R7 return busy cycles", 32'(cyc), 32'd7);
            chk("R5 R6 pc restore", {13'd0, pc}, {13'd0, ppc});
            chk("R5 psw restore", {24'd0, psw}, {24'd0, ppsw});
            chk("R5 aux restore", {16'd0, aux}, {16'd0, paux});
            spx = spx + 16'd6;
            chk("R5 R8 sp after return", {16'd0, sp}, {16'd0, spx});
            // Entry with a new vector and level.
            @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
            run_seq(1'b1, 1'b0, (i % 3 == 2) ? 4 : -1, vec, lvl, cyc);
            chk("R7 entry busy cycles", 32'(cyc), 32'd7);
            spx = spx - 16'd6;
            chk("R2 R8 sp after entry", {16'd0, sp}, {16'd0, spx});
            chk("R3 write count", 32'(wcnt), 32'd6);
            for (int k = 0; k < 6; k++)
                chk("R3 write order", {16'd0, wlog[k]}, {16'd0, spx + 16'(5 - k)});
            b = spx;
            chk("R2 slot psw", {24'd0, mem[b[7:0]]}, {24'd0, ppsw});
            chk("R2 slot pc low", {24'd0, mem[8'(b + 1)]}, {24'd0, ppc[8:1]});
            chk("R2 slot pc mid", {24'd0, mem[8'(b + 2)]}, {24'd0, ppc[16:9]});
            chk("R2 slot pc mixed", {24'd0, mem[8'(b + 3)]},
                {24'd0, ppc[0], 5'd0, ppc[18], ppc[17]});
            chk("R2 slot aux low", {24'd0, mem[8'(b + 4)]}, {24'd0, paux[7:0]});
            chk("R2 slot aux high", {24'd0, mem[8'(b + 5)]}, {24'd0, paux[15:8]});
            chk("R4 psw mask", {24'd0, psw}, {24'd0, lvl, ppsw[5:0]});
            chk("R4 pc vector", {13'd0, pc}, {13'd0, vec});
            chk("R4 aux kept", {16'd0, aux}, {16'd0, paux});
        end

        // R9: simultaneous strobes when idle perform entry.
        @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
        run_seq(1'b1, 1'b1, -1, 19'h5A5A5, 2'd3, cyc);
        spx = spx - 16'd6;
        chk("R9 sp entry chosen", {16'd0, sp}, {16'd0, spx});
        chk("R9 writes done", 32'(wcnt), 32'd6);
        chk("R9 pc vector", {13'd0, pc}, {13'd0, 19'h5A5A5});
        chk("R3 no write idle end", {31'd0, mem_we}, 32'd0);
        report();
    end
endmodule